// File: doc/BRIEF.md
# Basic-Rate Multiframe Q/S Channel Handler

This block follows the 20-frame multiframe of a basic-rate subscriber line, one frame at a time. On the receive side it scans a stream of paired data and control bits. A frame begins when both bits of a valid pair are 1. It keeps a frame index, checks each received multiframe mark against that index, and declares or drops multiframe lock. While locked, it gathers the bit carried at every fifth frame position into a 4-bit Q word, which it offers on a valid/ready output.

On the transmit side, each pulse on `tx_go` produces one outgoing frame start. The block inserts the both-ones pair and drives the multiframe mark, the Fa-position mark and the S-channel bit for that frame. A 4-bit S word is written through a valid/ready input. It takes effect at the next multiframe boundary, and each of its bits covers one group of five frames.

Top module: `qs_multiframe`

## Requirements
- R1: A received frame start is a cycle with `rx_vld`, `rx_dat` and `rx_ctl` all 1. The `rx_m` and `rx_fa` values are used only in that cycle. Every other cycle, including one with `rx_dat`=`rx_ctl`=1 but `rx_vld`=0, is ignored.
- R2: The receive frame index runs from 0 to 19 and wraps from 19 to 0. A frame start with `rx_m`=1 sets the index to 0. The Fa positions are indices 0, 5, 10 and 15.
- R3: Once the first `rx_m`=1 frame after reset has been seen, any later `rx_m`=1 frame that does not come at the 19-to-0 step sets `mf_misalign`. The flag then stays at 1 until reset.
- R4: An `rx_m`=1 frame at the 19-to-0 step is a good event. A misplaced `rx_m`=1 frame, or a frame with `rx_m`=0 at the 19-to-0 step, is a bad event. `mf_lock` goes to 1 on the second good event in a row and to 0 on the second bad event in a row. It is 1 from the cycle after that frame.
- R5: While locked, the `rx_fa` bit of the frame at index 5g is stored as Q(g+1). `q_data[3]` holds Q1 and `q_data[0]` holds Q4. `q_valid` rises the cycle after the index-15 frame start, but only if all four bits were taken while locked. The `rx_fa` bits of other frames have no effect.
- R6: `q_valid` stays high with `q_data` unchanged until a cycle with `q_ready`=1. If a new word arrives while the old one is still unaccepted, the new word replaces it and `q_overrun` is set. `q_overrun` stays at 1 until reset.
- R7: A cycle with `tx_go`=1 makes the next cycle a transmit frame start: `tx_vld`=`tx_dat`=`tx_ctl`=1. The transmit index starts at 0 after reset and steps 0 to 19 with each such frame. `tx_m`=1 only at index 0, and `tx_fa`=1 only at indices 0, 5, 10 and 15. When `tx_vld`=0, all transmit outputs are 0.
- R8: `s_data` is taken in a cycle with `s_valid`=`s_ready`=1. `s_ready` is 0 while a taken word is waiting. The waiting word becomes the active S word at the next index-0 transmit frame. In group g (indices 5g to 5g+4), `tx_s` is bit 3-g of the active word. If no new word is waiting, the active word is kept. It is 0 after reset.
- R9: After reset, `mf_lock`, `mf_misalign`, `q_valid`, `q_overrun` and `tx_vld` are 0, and `s_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_vld | input | 1 | Received bit pair is present this cycle |
| rx_dat | input | 1 | Received data bit |
| rx_ctl | input | 1 | Received control bit |
| rx_m | input | 1 | Received multiframe mark, read at frame start |
| rx_fa | input | 1 | Received Fa-position bit, read at frame start |
| mf_lock | output | 1 | Multiframe lock |
| mf_misalign | output | 1 | Sticky misplaced-mark flag |
| q_valid | output | 1 | Q word available |
| q_ready | input | 1 | Consumer takes the Q word |
| q_data | output | 4 | Q word, Q1 in the MSB |
| q_overrun | output | 1 | Sticky flag: a Q word was replaced before it was taken |
| tx_go | input | 1 | Request the next transmit frame |
| s_valid | input | 1 | S word offered |
| s_ready | output | 1 | S word can be taken |
| s_data | input | 4 | S word, the group-0 bit in the MSB |
| tx_vld | output | 1 | Transmit frame start |
| tx_dat | output | 1 | Transmitted data bit |
| tx_ctl | output | 1 | Transmitted control bit |
| tx_m | output | 1 | Transmitted multiframe mark |
| tx_fa | output | 1 | Transmitted Fa-position mark |
| tx_s | output | 1 | Transmitted S-channel bit |

## Verification
Multiframes with clean Fa positions show whether the Q bits land in the right places and in the right order. A run where Fa-position bits of 1 are sprinkled over the other frames, and where invalid both-ones pairs are mixed in, shows whether non-Q frames and non-frame cycles really leave the Q word and the frame index alone. A single missing mark, and then a misplaced mark followed by a missing one, show the difference between one bad event, which is tolerated, and two bad events in a row, which drop the lock. On the transmit side, S words are supplied before a boundary, never, and in the middle of a multiframe; this tells apart latching at index 0, holding the old word, and switching words too early.

// File: rtl/qs_mf_pkg.sv
package qs_mf_pkg;
  localparam int unsigned MF_LEN_DEF  = 20;
  localparam int unsigned GRP_LEN_DEF = 5;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_GOOD = 2'd1,
    EV_BAD  = 2'd2
  } mf_ev_e;
endpackage

// File: rtl/qs_rx_align.sv
module qs_rx_align
  import qs_mf_pkg::*;
#(
  parameter int unsigned MF_LEN = MF_LEN_DEF,
  parameter int unsigned CNT_W  = $clog2(MF_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fs_i,
  input  logic             m_i,
  output logic [CNT_W-1:0] idx_o,
  output logic             lock_nxt_o,
  output logic             locked_o,
  output logic             misalign_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MF_LEN - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic seen_q, seen_d, pg_q, pg_d, pb_q, pb_d;
  logic lock_q, lock_d, mis_q, mis_d;
  logic at_last;
  mf_ev_e ev;

  always_comb begin
    at_last = (cnt_q == LAST);
    idx_o   = (m_i || at_last) ? '0 : cnt_q + CNT_W'(1);
    ev      = EV_NONE;
    cnt_d   = cnt_q;
    seen_d  = seen_q;
    mis_d   = mis_q;
    pg_d    = pg_q;
    pb_d    = pb_q;
    lock_d  = lock_q;
    if (fs_i) begin
      cnt_d = idx_o;
      if (m_i) begin
        seen_d = 1'b1;
        if (seen_q) begin
          ev = at_last ? EV_GOOD : EV_BAD;
          if (!at_last) mis_d = 1'b1;
        end
      end else if (seen_q && at_last) begin
        ev = EV_BAD;
      end
    end
    case (ev)
      EV_GOOD: begin
        pg_d = 1'b1;
        pb_d = 1'b0;
        if (pg_q) lock_d = 1'b1;
      end
      EV_BAD: begin
        pb_d = 1'b1;
        pg_d = 1'b0;
        if (pb_q) lock_d = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= LAST;
      seen_q <= 1'b0;
      pg_q   <= 1'b0;
      pb_q   <= 1'b0;
      lock_q <= 1'b0;
      mis_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
      pg_q   <= pg_d;
      pb_q   <= pb_d;
      lock_q <= lock_d;
      mis_q  <= mis_d;
    end
  end

  assign lock_nxt_o = lock_d;
  assign locked_o   = lock_q;
  assign misalign_o = mis_q;

  a_r3_misalign_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    mis_q |=> mis_q);
  a_r2_mark_zeroes_index: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_i && m_i) |=> (cnt_q == '0));
  a_r4_lock_rises_on_mark: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(fs_i && m_i));
  a_r4_lock_falls_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> $past(fs_i));
endmodule

// File: rtl/qs_q_collect.sv
module qs_q_collect #(
  parameter int unsigned N_GRP   = 4,
  parameter int unsigned GRP_LEN = 5,
  parameter int unsigned CNT_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fs_i,
  input  logic [CNT_W-1:0] idx_i,
  input  logic             lock_i,
  input  logic             fa_i,
  input  logic             q_ready_i,
  output logic             q_valid_o,
  output logic [N_GRP-1:0] q_data_o,
  output logic             q_ovr_o
);
  logic [N_GRP-1:0] sh_q, sh_d, nib, dat_q, dat_d;
  logic ok_q, ok_d, vld_q, vld_d, ovr_q, ovr_d, done;
  int unsigned idx_u, grp_u, off_u;

  always_comb begin
    idx_u = 32'(idx_i);
    grp_u = idx_u / GRP_LEN;
    off_u = idx_u % GRP_LEN;
    sh_d  = sh_q;
    ok_d  = ok_q;
    nib   = sh_q;
    done  = 1'b0;
    if (fs_i && off_u == 0) begin
      if (!lock_i) begin
        ok_d = 1'b0;
      end else begin
        nib[N_GRP-1-grp_u] = fa_i;
        sh_d = nib;
        ok_d = (grp_u == 0) ? 1'b1 : ok_q;
        done = (grp_u == N_GRP - 1) && ok_d;
      end
    end
  end

  always_comb begin
    vld_d = vld_q;
    dat_d = dat_q;
    ovr_d = ovr_q;
    if (done) begin
      vld_d = 1'b1;
      dat_d = nib;
      if (vld_q && !q_ready_i) ovr_d = 1'b1;
    end else if (vld_q && q_ready_i) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      ok_q  <= 1'b0;
      vld_q <= 1'b0;
      dat_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      ok_q  <= ok_d;
      vld_q <= vld_d;
      dat_q <= dat_d;
      ovr_q <= ovr_d;
    end
  end

  assign q_valid_o = vld_q;
  assign q_data_o  = dat_q;
  assign q_ovr_o   = ovr_q;

  a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> ovr_q);
  a_r6_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !q_ready_i && !(fs_i && lock_i)) |=> (vld_q && $stable(dat_q)));
  a_r5_valid_from_locked_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld_q) |-> $past(fs_i && lock_i));
endmodule

// File: rtl/qs_tx_gen.sv
module qs_tx_gen #(
  parameter int unsigned MF_LEN  = 20,
  parameter int unsigned N_GRP   = 4,
  parameter int unsigned GRP_LEN = 5,
  parameter int unsigned CNT_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_go_i,
  input  logic             s_valid_i,
  output logic             s_ready_o,
  input  logic [N_GRP-1:0] s_data_i,
  output logic             tx_vld_o,
  output logic             tx_dat_o,
  output logic             tx_ctl_o,
  output logic             tx_m_o,
  output logic             tx_fa_o,
  output logic             tx_s_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MF_LEN - 1);

  logic [CNT_W-1:0] tidx_q, tidx_d;
  logic [N_GRP-1:0] pend_q, pend_d, word_q, word_d, word_use;
  logic pv_q, pv_d;
  logic vld_q, vld_d, m_q, m_d, fa_q, fa_d, s_q, s_d;
  int unsigned tidx_u;

  always_comb begin
    tidx_u    = 32'(tidx_q);
    s_ready_o = !pv_q;
    word_use  = (tidx_q == '0 && pv_q) ? pend_q : word_q;
    tidx_d    = tidx_q;
    pend_d    = pend_q;
    pv_d      = pv_q;
    word_d    = word_q;
    vld_d     = 1'b0;
    m_d       = 1'b0;
    fa_d      = 1'b0;
    s_d       = 1'b0;
    if (tx_go_i) begin
      if (tidx_q == '0) begin
        word_d = word_use;
        pv_d   = 1'b0;
      end
      vld_d  = 1'b1;
      m_d    = (tidx_q == '0);
      fa_d   = (tidx_u % GRP_LEN) == 0;
      s_d    = word_use[N_GRP-1-(tidx_u / GRP_LEN)];
      tidx_d = (tidx_q == LAST) ? '0 : tidx_q + CNT_W'(1);
    end
    if (s_valid_i && !pv_q) begin
      pend_d = s_data_i;
      pv_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tidx_q <= '0;
      pend_q <= '0;
      pv_q   <= 1'b0;
      word_q <= '0;
      vld_q  <= 1'b0;
      m_q    <= 1'b0;
      fa_q   <= 1'b0;
      s_q    <= 1'b0;
    end else begin
      tidx_q <= tidx_d;
      pend_q <= pend_d;
      pv_q   <= pv_d;
      word_q <= word_d;
      vld_q  <= vld_d;
      m_q    <= m_d;
      fa_q   <= fa_d;
      s_q    <= s_d;
    end
  end

  assign tx_vld_o = vld_q;
  assign tx_dat_o = vld_q;
  assign tx_ctl_o = vld_q;
  assign tx_m_o   = m_q;
  assign tx_fa_o  = fa_q;
  assign tx_s_o   = s_q;

  a_r7_frame_follows_go: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q == $past(tx_go_i));
  a_r7_mark_on_fa_frame: assert property (@(posedge clk) disable iff (!rst_n)
    m_q |-> (vld_q && fa_q));
  a_r8_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid_i && s_ready_o) |=> !s_ready_o);
endmodule

// File: rtl/qs_multiframe.sv
module qs_multiframe
  import qs_mf_pkg::*;
#(
  parameter int unsigned MF_LEN  = MF_LEN_DEF,
  parameter int unsigned GRP_LEN = GRP_LEN_DEF,
  localparam int unsigned N_GRP  = MF_LEN / GRP_LEN,
  localparam int unsigned CNT_W  = $clog2(MF_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_vld,
  input  logic             rx_dat,
  input  logic             rx_ctl,
  input  logic             rx_m,
  input  logic             rx_fa,
  output logic             mf_lock,
  output logic             mf_misalign,
  output logic             q_valid,
  input  logic             q_ready,
  output logic [N_GRP-1:0] q_data,
  output logic             q_overrun,
  input  logic             tx_go,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [N_GRP-1:0] s_data,
  output logic             tx_vld,
  output logic             tx_dat,
  output logic             tx_ctl,
  output logic             tx_m,
  output logic             tx_fa,
  output logic             tx_s
);
  logic             fs;
  logic [CNT_W-1:0] idx;
  logic             lock_nxt;

  assign fs = rx_vld && rx_dat && rx_ctl;

  qs_rx_align #(.MF_LEN(MF_LEN), .CNT_W(CNT_W)) u_align (
    .clk        (clk),
    .rst_n      (rst_n),
    .fs_i       (fs),
    .m_i        (rx_m),
    .idx_o      (idx),
    .lock_nxt_o (lock_nxt),
    .locked_o   (mf_lock),
    .misalign_o (mf_misalign)
  );

  qs_q_collect #(.N_GRP(N_GRP), .GRP_LEN(GRP_LEN), .CNT_W(CNT_W)) u_qcol (
    .clk       (clk),
    .rst_n     (rst_n),
    .fs_i      (fs),
    .idx_i     (idx),
    .lock_i    (lock_nxt),
    .fa_i      (rx_fa),
    .q_ready_i (q_ready),
    .q_valid_o (q_valid),
    .q_data_o  (q_data),
    .q_ovr_o   (q_overrun)
  );

  qs_tx_gen #(.MF_LEN(MF_LEN), .N_GRP(N_GRP), .GRP_LEN(GRP_LEN), .CNT_W(CNT_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_go_i   (tx_go),
    .s_valid_i (s_valid),
    .s_ready_o (s_ready),
    .s_data_i  (s_data),
    .tx_vld_o  (tx_vld),
    .tx_dat_o  (tx_dat),
    .tx_ctl_o  (tx_ctl),
    .tx_m_o    (tx_m),
    .tx_fa_o   (tx_fa),
    .tx_s_o    (tx_s)
  );

  a_r1_no_mark_effect_off_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (!fs) |=> $stable(mf_misalign));
endmodule

// File: tb/tb_qs_multiframe.sv
module tb_qs_multiframe;
  logic clk = 1'b0;
  logic rst_n;
  logic rx_vld, rx_dat, rx_ctl, rx_m, rx_fa;
  logic mf_lock, mf_misalign, q_valid, q_ready, q_overrun;
  logic [3:0] q_data, s_data;
  logic tx_go, s_valid, s_ready;
  logic tx_vld, tx_dat, tx_ctl, tx_m, tx_fa, tx_s;

  int n_run = 0;
  int n_fail = 0;

  logic [3:0] q_exp[$];
  logic [2:0] tx_exp[$];

  int         m_tidx = 0;
  logic       m_pv = 1'b0;
  logic [3:0] m_pend = '0;
  logic [3:0] m_word = '0;

  always #4 clk = ~clk;

  qs_multiframe dut (
    .clk(clk), .rst_n(rst_n),
    .rx_vld(rx_vld), .rx_dat(rx_dat), .rx_ctl(rx_ctl), .rx_m(rx_m), .rx_fa(rx_fa),
    .mf_lock(mf_lock), .mf_misalign(mf_misalign),
    .q_valid(q_valid), .q_ready(q_ready), .q_data(q_data), .q_overrun(q_overrun),
    .tx_go(tx_go), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .tx_vld(tx_vld), .tx_dat(tx_dat), .tx_ctl(tx_ctl), .tx_m(tx_m), .tx_fa(tx_fa), .tx_s(tx_s)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (q_valid && q_ready) begin
        if (q_exp.size() == 0) check(1'b0, "R5 unexpected Q word", int'(q_data), -1);
        else begin
          logic [3:0] e;
          e = q_exp.pop_front();
          check(q_data == e, "R5 Q word", int'(q_data), int'(e));
        end
      end
      if (tx_vld) begin
        check(tx_dat && tx_ctl, "R7 both-ones pair", int'({tx_dat, tx_ctl}), 3);
        if (tx_exp.size() == 0) check(1'b0, "R7 unexpected tx frame", 0, -1);
        else begin
          logic [2:0] e;
          e = tx_exp.pop_front();
          check(tx_m == e[2] && tx_fa == e[1], "R7 tx marks", int'({tx_m, tx_fa}), int'(e[2:1]));
          check(tx_s == e[0], "R8 tx S bit", int'(tx_s), int'(e[0]));
        end
      end
    end
  end

  task automatic rx_sym(input logic v, input logic d, input logic c, input logic m, input logic fa);
    @(posedge clk); #2;
    rx_vld = v; rx_dat = d; rx_ctl = c; rx_m = m; rx_fa = fa;
  endtask

  task automatic rx_idle();
    @(posedge clk); #2;
    rx_vld = 1'b0; rx_dat = 1'b0; rx_ctl = 1'b0; rx_m = 1'b0; rx_fa = 1'b0;
    @(negedge clk);
  endtask

  // R1: a frame start followed by two non-start cycles carrying junk marks
  task automatic rx_frame(input logic m, input logic fa);
    rx_sym(1'b1, 1'b1, 1'b1, m, fa);
    rx_sym(1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    rx_sym(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic rx_mf(input logic m, input logic [3:0] q, input logic noise, input bit expect_q);
    if (expect_q) q_exp.push_back(q);
    for (int i = 0; i < 20; i++) begin
      logic fa;
      fa = (i % 5 == 0) ? q[3 - i / 5] : noise;
      rx_frame((i == 0) ? m : 1'b0, fa);
    end
  endtask

  task automatic tx_frame();
    logic [2:0] e;
    if (m_tidx == 0 && m_pv) begin
      m_word = m_pend;
      m_pv   = 1'b0;
    end
    e = {m_tidx == 0, m_tidx % 5 == 0, m_word[3 - m_tidx / 5]};
    tx_exp.push_back(e);
    m_tidx = (m_tidx + 1) % 20;
    @(posedge clk); #2; tx_go = 1'b1;
    @(posedge clk); #2; tx_go = 1'b0;
  endtask

  task automatic s_submit(input logic [3:0] d);
    @(posedge clk); #2;
    while (!s_ready) begin
      @(posedge clk); #2;
    end
    s_valid = 1'b1; s_data = d;
    m_pv = 1'b1; m_pend = d;
    @(posedge clk); #2; s_valid = 1'b0;
    @(negedge clk);
    check(!s_ready, "R8 s_ready low while waiting", int'(s_ready), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    rx_vld = 0; rx_dat = 0; rx_ctl = 0; rx_m = 0; rx_fa = 0;
    q_ready = 1'b1; tx_go = 0; s_valid = 0; s_data = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!mf_lock && !mf_misalign, "R9 lock/misalign reset", int'({mf_lock, mf_misalign}), 0);
    check(!q_valid && !q_overrun, "R9 Q outputs reset", int'({q_valid, q_overrun}), 0);
    check(!tx_vld && s_ready, "R9 tx/s_ready reset", int'({tx_vld, s_ready}), 1);
    @(posedge clk); #2; rst_n = 1'b1;

    // R4: lock needs two good intervals in a row
    rx_mf(1'b1, 4'hA, 1'b0, 0);
    rx_mf(1'b1, 4'h5, 1'b0, 0);
    rx_idle();
    check(!mf_lock, "R4 no lock after one good interval", int'(mf_lock), 0);
    rx_mf(1'b1, 4'h9, 1'b0, 1);
    rx_idle();
    check(mf_lock, "R4 lock after two good intervals", int'(mf_lock), 1);
    check(!mf_misalign, "R3 clean marks leave flag low", int'(mf_misalign), 0);

    // R1, R5: noise in non-Q frames must not disturb the word
    rx_mf(1'b1, 4'h3, 1'b1, 1);
    rx_mf(1'b1, 4'hE, 1'b1, 1);
    // R2, R4: one missing mark keeps lock, index wraps anyway
    rx_mf(1'b0, 4'hC, 1'b0, 1);
    rx_idle();
    check(mf_lock, "R4 one missing mark tolerated", int'(mf_lock), 1);
    rx_mf(1'b1, 4'h6, 1'b0, 1);
    rx_idle();
    check(q_exp.size() == 0, "R5 all Q words delivered", q_exp.size(), 0);

    // R6: overrun
    check(!q_overrun, "R6 no overrun yet", int'(q_overrun), 0);
    @(posedge clk); #2; q_ready = 1'b0;
    rx_mf(1'b1, 4'h1, 1'b0, 0);
    rx_mf(1'b1, 4'h2, 1'b0, 0);
    rx_idle();
    check(q_valid && q_data == 4'h2, "R6 newest word held", int'(q_data), 2);
    check(q_overrun, "R6 overrun flagged", int'(q_overrun), 1);
    q_exp.push_back(4'h2);
    @(posedge clk); #2; q_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!q_valid, "R6 valid drops after take", int'(q_valid), 0);
    check(q_overrun, "R6 overrun sticky", int'(q_overrun), 1);

    // R3, R4: misplaced mark then missing mark
    rx_frame(1'b1, 1'b0);
    for (int i = 1; i < 7; i++) rx_frame(1'b0, 1'b0);
    q_exp.push_back(4'h0);
    rx_frame(1'b1, 1'b0);
    for (int i = 1; i < 20; i++) rx_frame(1'b0, 1'b0);
    rx_idle();
    check(mf_misalign, "R3 misplaced mark flagged", int'(mf_misalign), 1);
    check(mf_lock, "R4 one bad event keeps lock", int'(mf_lock), 1);
    rx_frame(1'b0, 1'b1);
    rx_idle();
    check(!mf_lock, "R4 second bad event drops lock", int'(mf_lock), 0);
    check(mf_misalign, "R3 flag sticky", int'(mf_misalign), 1);
    check(q_exp.size() == 0, "R5 misplaced-run word delivered", q_exp.size(), 0);

    // R7, R8: transmit
    for (int i = 0; i < 20; i++) tx_frame();
    s_submit(4'hA);
    for (int i = 0; i < 20; i++) tx_frame();
    @(negedge clk);
    check(s_ready, "R8 s_ready back after latch", int'(s_ready), 1);
    for (int i = 0; i < 20; i++) tx_frame();
    for (int i = 0; i < 7; i++) tx_frame();
    s_submit(4'h6);
    for (int i = 0; i < 13; i++) tx_frame();
    for (int i = 0; i < 20; i++) tx_frame();
    repeat (3) @(negedge clk);
    check(tx_exp.size() == 0, "R7 all tx frames seen", tx_exp.size(), 0);
    check(!tx_vld, "R7 idle outputs low", int'({tx_vld, tx_m, tx_fa, tx_s}), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule